// File: doc/BRIEF.md
# Serial Self-Stripping Cage Routing Cell

This block is one vertex of a chain of routing cells that form a wire cage around a protected circuit. Each cell has six one-bit links, one per axis direction (x+, x-, y+, y-, z+, z-). Each link is modelled as an input pin plus an output pin with an enable. A 5-bit route code picks one ordered pair of links: the input link that the cell listens on and the output link that it drives. Messages travel bit-serially, one bit per clock, from cell to cell along that path.

A message has two framed parts, each opened by a single `1` marker bit on an idle-low line. The first part is a header made of 5-bit route fields, one per remaining cell. Each field is sent MSB first, and the field for the receiving cell comes first. The second part is a payload word. The cell keeps the first field it receives as its route for the next session and forwards only the rest of the header. It then gathers the payload and sends back a keyed tag of it. The tag is built only from XOR with a fixed key and the running cell state, followed by a fixed bit rotation. The same step folds the payload into the cell state. A chip-wide reconfigure strobe makes every cell switch to its stored route at the end of a session. The protected circuit then compares the tag that leaves the final cell against its own computation.

Top module: `canary_cell`

## Requirements
- R1: A route code selects one (input, output) link pair, with links numbered x+=0, x-=1, y+=2, y-=3, z+=4, z-=5. A code c < 0x0F covers the pairs a<b in row-major order (0x00=(0,1), 0x01=(0,2) … 0x0E=(4,5)). Code 0x10+k is the same pair as code k with input and output swapped. At most one output enable is high, it is the one for the decoded output link, and data appears only on that link.
- R2: Codes 0x0F and 0x1F, and any code that names a link cleared in `PORT_MASK`, mean "no route". In that case `route_err` is 1, all enables and outputs are 0, and every input is ignored.
- R3: After a start marker, the cell captures the next 5 bits as its next route (MSB first) and does not forward them. The output starts with a marker bit followed by the remaining 5·(N_CELLS−CELL_IDX−1) header bits, in order.
- R4: After an idle gap of any length, a second marker opens a PW-bit payload P, sent MSB first. The cell then sends a marker followed by rotl(P ^ KEY ^ S, ROT), MSB first, where S is the cell state.
- R5: Each payload updates the state: S ← rotl(S ^ P, 1) ^ route, where route is the current 5-bit code, zero-extended. The state changes at no other time.
- R6: When `reconf` is high, all output enables are 0 in that cycle. At the following edge, the current route takes the stored next route and `session` increments by one.
- R7: Reset sets the route to `DEF_ROUTE` and sets the state, `session`, `busy` and all outputs to 0.
- R8: `busy` rises in the cycle after the start marker is sampled. It stays high until the last tag bit has been on the output, then falls. While `busy` is low, all outputs are 0.
- R9: Bits on links other than the selected input, including marker-like ones, have no effect on the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reconf | input | 1 | Session-boundary strobe: switch to the stored route |
| port_in | input | 6 | Incoming bit on each link (index = link number) |
| port_out | output | 6 | Outgoing bit on each link |
| port_oe | output | 6 | Output enable on each link |
| route_err | output | 1 | Current route code is illegal or names an absent link |
| busy | output | 1 | A message is being received or sent |
| session | output | SESS_W | Count of reconfigurations since reset |

## Verification
The state update is the hardest thing to reach from the pins. It is never visible directly and only shows up in the tag of a later payload. It also mixes in the route that was in force when the earlier payload arrived. The stimulus therefore sends chains of messages, with and without reconfiguration between them, so that a wrong state or the wrong route in the update changes every later tag. Random header contents, random idle gaps and random junk on the unselected links run alongside directed cases for illegal codes, a link missing on a boundary cell, and a reset in the middle of the sequence.

// File: rtl/canary_pkg.sv
`timescale 1ns/1ps
package canary_pkg;
   localparam int RT_W  = 5;
   localparam int NPORT = 6;

   typedef logic [RT_W-1:0] route_code_t;

   typedef struct packed {
      logic       valid;
      logic [2:0] src;
      logic [2:0] dst;
   } hop_t;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_HDR,
      PH_FWD,
      PH_WAITP,
      PH_COLL,
      PH_EMIT,
      PH_TAIL
   } phase_t;

   // low nibble enumerates ordered pairs a<b; top bit swaps direction
   function automatic hop_t decode_route(route_code_t code);
      hop_t h;
      int   k;
      h = '0;
      k = 0;
      for (int a = 0; a < NPORT; a++) begin
         for (int b = a + 1; b < NPORT; b++) begin
            if (int'(code[3:0]) == k) begin
               h.valid = 1'b1;
               if (code[4]) begin
                  h.src = 3'(b);
                  h.dst = 3'(a);
               end else begin
                  h.src = 3'(a);
                  h.dst = 3'(b);
               end
            end
            k++;
         end
      end
      return h;
   endfunction
endpackage

// File: rtl/canary_route_dec.sv
`timescale 1ns/1ps
module canary_route_dec
   import canary_pkg::*;
#(
   parameter logic [NPORT-1:0] PORT_MASK = '1
) (
   input  logic [RT_W-1:0]  code,
   output logic [NPORT-1:0] in_sel,
   output logic [NPORT-1:0] out_sel,
   output logic             err
);
   hop_t hop;
   logic ok;

   assign hop = decode_route(code);
   assign ok  = hop.valid && PORT_MASK[hop.src] && PORT_MASK[hop.dst];
   assign err = !ok;

   for (genvar p = 0; p < NPORT; p++) begin : g_sel
      assign in_sel[p]  = ok && (hop.src == 3'(p));
      assign out_sel[p] = ok && (hop.dst == 3'(p));
   end
endmodule

// File: rtl/canary_mac.sv
`timescale 1ns/1ps
module canary_mac
   import canary_pkg::*;
#(
   parameter int          PW        = 64,
   parameter int          ROT       = 13,
   parameter int          PERM_MODE = 0,
   parameter logic [PW-1:0] KEY     = '0
) (
   input  logic [PW-1:0]   payload,
   input  logic [PW-1:0]   state,
   input  logic [RT_W-1:0] route,
   output logic [PW-1:0]   tag,
   output logic [PW-1:0]   nxt_state
);
   logic [PW-1:0] mixed;
   logic [PW-1:0] shaped;
   logic [PW-1:0] chain;

   assign mixed = payload ^ KEY ^ state;

   if (PERM_MODE == 0) begin : g_rot_only
      assign shaped = mixed;
   end else begin : g_rev_rot
      for (genvar b = 0; b < PW; b++) begin : g_rev
         assign shaped[b] = mixed[PW-1-b];
      end
   end

   assign tag       = (shaped << ROT) | (shaped >> (PW - ROT));
   assign chain     = state ^ payload;
   assign nxt_state = {chain[PW-2:0], chain[PW-1]} ^ {{(PW-RT_W){1'b0}}, route};
endmodule

// File: rtl/canary_cell.sv
`timescale 1ns/1ps
module canary_cell
   import canary_pkg::*;
#(
   parameter int               N_CELLS   = 8,
   parameter int               CELL_IDX  = 2,
   parameter int               PW        = 64,
   parameter int               ROT       = 13,
   parameter int               PERM_MODE = 0,
   parameter logic [PW-1:0]    KEY       = 64'hC3A5_5A3C_0F96_E178,
   parameter logic [RT_W-1:0]  DEF_ROUTE = 5'h13,
   parameter logic [NPORT-1:0] PORT_MASK = 6'h3F,
   parameter int               SESS_W    = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reconf,
   input  logic [5:0]        port_in,
   output logic [5:0]        port_out,
   output logic [5:0]        port_oe,
   output logic              route_err,
   output logic              busy,
   output logic [SESS_W-1:0] session
);
   localparam int FWD_BITS = RT_W * (N_CELLS - CELL_IDX - 1);
   localparam int MAXLEN   = (PW > FWD_BITS) ? PW : FWD_BITS;
   localparam int CNT_W    = $clog2(MAXLEN + 1);
   localparam logic [CNT_W-1:0] OWN_LAST = CNT_W'(RT_W - 1);
   localparam logic [CNT_W-1:0] FWD_LAST = CNT_W'((FWD_BITS > 0) ? FWD_BITS - 1 : 0);
   localparam logic [CNT_W-1:0] PW_LAST  = CNT_W'(PW - 1);

   if (CELL_IDX < 0 || CELL_IDX >= N_CELLS) begin : g_bad_idx
      $error("canary_cell: CELL_IDX outside chain");
   end
   if (ROT < 1 || ROT >= PW) begin : g_bad_rot
      $error("canary_cell: ROT must lie in 1..PW-1");
   end
   if (PW < 8) begin : g_bad_pw
      $error("canary_cell: PW too small");
   end

   phase_t            phase;
   logic [CNT_W-1:0]  cnt;
   logic              tx;
   route_code_t       cur_rt;
   route_code_t       nxt_rt;
   logic [PW-1:0]     shreg;
   logic [PW-1:0]     mac_st;
   logic [SESS_W-1:0] sess;
   logic [NPORT-1:0]  in_sel;
   logic [NPORT-1:0]  out_sel;
   logic              rx;
   logic [PW-1:0]     word_in;
   logic [PW-1:0]     tag;
   logic [PW-1:0]     st_next;

   canary_route_dec #(.PORT_MASK(PORT_MASK)) u_dec (
      .code    (cur_rt),
      .in_sel  (in_sel),
      .out_sel (out_sel),
      .err     (route_err)
   );

   assign rx      = |(port_in & in_sel);
   assign word_in = {shreg[PW-2:0], rx};

   canary_mac #(.PW(PW), .ROT(ROT), .PERM_MODE(PERM_MODE), .KEY(KEY)) u_mac (
      .payload   (word_in),
      .state     (mac_st),
      .route     (cur_rt),
      .tag       (tag),
      .nxt_state (st_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         cnt    <= '0;
         tx     <= 1'b0;
         cur_rt <= DEF_ROUTE;
         nxt_rt <= DEF_ROUTE;
         shreg  <= '0;
         mac_st <= '0;
         sess   <= '0;
      end else begin
         if (reconf) begin
            cur_rt <= nxt_rt;
            sess   <= sess + 1'b1;
         end
         case (phase)
            PH_IDLE: begin
               tx <= 1'b0;
               if (rx) begin
                  phase <= PH_HDR;
                  cnt   <= '0;
               end
            end
            PH_HDR: begin
               nxt_rt <= {nxt_rt[RT_W-2:0], rx};
               cnt    <= cnt + 1'b1;
               tx     <= 1'b0;
               if (cnt == OWN_LAST) begin
                  cnt <= '0;
                  if (FWD_BITS > 0) begin
                     tx    <= 1'b1;
                     phase <= PH_FWD;
                  end else begin
                     phase <= PH_WAITP;
                  end
               end
            end
            PH_FWD: begin
               tx  <= rx;
               cnt <= cnt + 1'b1;
               if (cnt == FWD_LAST) begin
                  cnt   <= '0;
                  phase <= PH_WAITP;
               end
            end
            PH_WAITP: begin
               tx <= 1'b0;
               if (rx) begin
                  phase <= PH_COLL;
                  cnt   <= '0;
               end
            end
            PH_COLL: begin
               shreg <= word_in;
               cnt   <= cnt + 1'b1;
               tx    <= 1'b0;
               if (cnt == PW_LAST) begin
                  shreg  <= tag;
                  mac_st <= st_next;
                  tx     <= 1'b1;
                  cnt    <= '0;
                  phase  <= PH_EMIT;
               end
            end
            PH_EMIT: begin
               tx    <= shreg[PW-1];
               shreg <= {shreg[PW-2:0], 1'b0};
               cnt   <= cnt + 1'b1;
               if (cnt == PW_LAST) begin
                  phase <= PH_TAIL;
               end
            end
            default: begin
               tx    <= 1'b0;
               phase <= PH_IDLE;
            end
         endcase
      end
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_drv
      assign port_oe[p]  = out_sel[p] & ~reconf;
      assign port_out[p] = tx & out_sel[p] & ~reconf;
   end

   assign busy    = (phase != PH_IDLE);
   assign session = sess;

   AST_OE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_oe)); // R1
   AST_DATA_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (port_out & ~port_oe) == '0); // R1
   AST_OE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (port_oe & ~PORT_MASK) == '0); // R2
   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      route_err |-> (port_oe == '0)); // R2
   AST_RECONF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      reconf |-> (port_oe == '0)); // R6
   AST_SESS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      reconf |=> (session == SESS_W'($past(session) + 1'b1))); // R6
   AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_COLL) |=> $stable(mac_st)); // R5
   AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (port_out == '0)); // R8
endmodule

// File: tb/test_canary_cell.sv
`timescale 1ns/1ps
module test_canary_cell;
   localparam int N    = 8;
   localparam int IDX  = 2;
   localparam int PW   = 64;
   localparam int ROT  = 13;
   localparam int FW   = 5 * (N - IDX - 1);
   localparam int HW   = 5 * (N - IDX);
   localparam logic [63:0] KEY = 64'hC3A5_5A3C_0F96_E178;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reconf = 1'b0;
   logic [5:0] port_in = '0;
   logic [5:0] port_out, port_oe, e_out, e_oe;
   logic       route_err, busy, e_err, e_busy;
   logic [7:0] session, e_sess;

   always #10 clk = ~clk;

   canary_cell #(.N_CELLS(N), .CELL_IDX(IDX), .PW(PW), .ROT(ROT), .KEY(KEY),
                 .DEF_ROUTE(5'h13), .PORT_MASK(6'h3F)) i_canary_cell (
      .clk(clk), .rst_n(rst_n), .reconf(reconf), .port_in(port_in),
      .port_out(port_out), .port_oe(port_oe), .route_err(route_err),
      .busy(busy), .session(session));

   canary_cell #(.N_CELLS(N), .CELL_IDX(IDX), .PW(PW), .ROT(ROT), .KEY(KEY),
                 .DEF_ROUTE(5'h13), .PORT_MASK(6'h1F)) i_canary_cell_edge (
      .clk(clk), .rst_n(rst_n), .reconf(reconf), .port_in(port_in),
      .port_out(e_out), .port_oe(e_oe), .route_err(e_err),
      .busy(e_busy), .session(e_sess));

   int checks = 0;
   int fails  = 0;

   logic [4:0]  m_cur = 5'h13;
   logic [4:0]  m_next = 5'h13;
   logic [63:0] m_st = '0;
   int          m_sess = 0;

   logic rec_on = 1'b0;
   int   obs = 0;
   logic oq[$];
   bit   stray = 1'b0;
   logic last_busy;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit pair_of(input logic [4:0] c, output int s, output int d);
      bit v = 1'b1;
      case (c)
         5'h00: begin s=0; d=1; end  5'h01: begin s=0; d=2; end
         5'h02: begin s=0; d=3; end  5'h03: begin s=0; d=4; end
         5'h04: begin s=0; d=5; end  5'h05: begin s=1; d=2; end
         5'h06: begin s=1; d=3; end  5'h07: begin s=1; d=4; end
         5'h08: begin s=1; d=5; end  5'h09: begin s=2; d=3; end
         5'h0A: begin s=2; d=4; end  5'h0B: begin s=2; d=5; end
         5'h0C: begin s=3; d=4; end  5'h0D: begin s=3; d=5; end
         5'h0E: begin s=4; d=5; end  5'h10: begin s=1; d=0; end
         5'h11: begin s=2; d=0; end  5'h12: begin s=3; d=0; end
         5'h13: begin s=4; d=0; end  5'h14: begin s=5; d=0; end
         5'h15: begin s=2; d=1; end  5'h16: begin s=3; d=1; end
         5'h17: begin s=4; d=1; end  5'h18: begin s=5; d=1; end
         5'h19: begin s=3; d=2; end  5'h1A: begin s=4; d=2; end
         5'h1B: begin s=5; d=2; end  5'h1C: begin s=4; d=3; end
         5'h1D: begin s=5; d=3; end  5'h1E: begin s=5; d=4; end
         default: begin s=0; d=0; v=1'b0; end
      endcase
      return v;
   endfunction

   function automatic logic [63:0] rotl(input logic [63:0] x, input int r);
      return (x << r) | (x >> (64 - r));
   endfunction

   function automatic logic qget(input int i);
      return (i < oq.size()) ? oq[i] : 1'b0;
   endfunction

   always @(negedge clk) begin
      if (rec_on) begin
         oq.push_back(port_out[obs]);
         if ((port_out & ~(6'd1 << obs)) != 6'd0) stray = 1'b1;
      end
   end

   task automatic drive_bit(input int src, input logic b);
      @(negedge clk);
      last_busy = busy;
      port_in      = 6'($urandom);
      port_in[src] = b;
   endtask

   task automatic send_msg(input logic [HW-1:0] hdr, input logic [63:0] pl,
                           input int gap, input bit chk_busy);
      int s, d, p;
      logic [FW-1:0] got_f;
      logic [63:0]   got_t, exp_t;
      void'(pair_of(m_cur, s, d));
      obs = d; oq.delete(); stray = 1'b0; rec_on = 1'b1;
      drive_bit(s, 1'b1);
      if (chk_busy) chk(last_busy == 1'b0, "R8", "busy before marker", 64'(last_busy), 0);
      for (int j = HW - 1; j >= 0; j--) begin
         drive_bit(s, hdr[j]);
         if (chk_busy && j == HW - 1)
            chk(last_busy == 1'b1, "R8", "busy after marker", 64'(last_busy), 1);
      end
      for (int g = 0; g < gap; g++) drive_bit(s, 1'b0);
      drive_bit(s, 1'b1);
      for (int j = 63; j >= 0; j--) drive_bit(s, pl[j]);
      for (int g = 0; g < 72; g++) drive_bit(s, 1'b0);
      @(negedge clk);
      rec_on = 1'b0;
      chk(busy == 1'b0, "R8", "busy after tag sent", 64'(busy), 0);
      p = 0;
      while (p < oq.size() && oq[p] == 1'b0) p++;
      got_f = '0;
      for (int j = 0; j < FW; j++) got_f = {got_f[FW-2:0], qget(p + 1 + j)};
      p = p + 1 + FW;
      while (p < oq.size() && oq[p] == 1'b0) p++;
      got_t = '0;
      for (int j = 0; j < 64; j++) got_t = {got_t[62:0], qget(p + 1 + j)};
      exp_t = rotl(pl ^ KEY ^ m_st, ROT);
      chk(got_f == hdr[FW-1:0], "R3", "forwarded header", 64'(got_f), 64'(hdr[FW-1:0]));
      chk(got_t == exp_t, "R4", "payload tag", got_t, exp_t);
      chk(stray == 1'b0, "R9", "no leak to other links", 64'(stray), 0);
      m_st   = rotl(m_st ^ pl, 1) ^ {59'd0, m_cur};
      m_next = hdr[HW-1:HW-5];
      port_in = '0;
   endtask

   task automatic do_reconf();
      int s, d;
      bit v;
      @(negedge clk);
      reconf = 1'b1;
      #1;
      chk(port_oe == 6'd0, "R6", "enables off during strobe", 64'(port_oe), 0);
      @(negedge clk);
      reconf = 1'b0;
      m_cur = m_next;
      m_sess++;
      #1;
      chk(session == 8'(m_sess), "R6", "session count", 64'(session), 64'(m_sess));
      v = pair_of(m_cur, s, d);
      if (v) begin
         chk(port_oe == (6'd1 << d) && !route_err, "R1", "enable on decoded output",
             64'(port_oe), 64'(6'd1 << d));
      end else begin
         chk(port_oe == 6'd0 && route_err, "R2", "illegal code silences cell",
             64'({route_err, port_oe}), 64'h40);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [4:0] c;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      chk(port_oe == 6'h01 && !route_err && busy == 1'b0 && port_out == 6'd0 && session == 8'd0,
          "R7", "reset state", 64'({route_err, busy, port_out, port_oe, session}), 64'h01);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // first message: own field 0x0B (y+ -> z-), valid here, absent link on edge cell
      send_msg({5'h0B, 25'h1A5_5A5A}, 64'h0123_4567_89AB_CDEF, 0, 1'b1);
      send_msg({5'h0B, 25'h0F0_F0F0}, 64'hFFFF_0000_FFFF_0000, 3, 1'b0);
      do_reconf();
      chk(e_err == 1'b1 && e_oe == 6'd0, "R2", "masked link on boundary cell",
          64'({e_err, e_oe}), 64'h40);

      for (int it = 0; it < 8; it++) begin
         do c = 5'($urandom); while (c[3:0] == 4'hF);
         send_msg({c, 25'($urandom)}, {$urandom, $urandom}, $urandom % 6, 1'b0);
         if (it % 3 != 2) do_reconf();
      end

      // illegal code: cell goes silent and ignores all links
      send_msg({5'h1F, 25'h155_5555}, 64'hDEAD_BEEF_0BAD_F00D, 1, 1'b0);
      do_reconf();
      stray = 1'b0;
      for (int g = 0; g < 100; g++) begin
         @(negedge clk);
         port_in = (g % 7 == 0) ? 6'h3F : 6'($urandom);
         if (busy || port_out != 6'd0) stray = 1'b1;
      end
      chk(stray == 1'b0, "R2", "inputs ignored with no route", 64'(stray), 0);
      port_in = '0;

      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(port_oe == 6'h01 && !route_err && session == 8'd0 && busy == 1'b0,
          "R7", "state after second reset", 64'({route_err, busy, port_oe, session}), 64'h01);
      rst_n = 1'b1;
      m_cur = 5'h13; m_next = 5'h13; m_st = '0; m_sess = 0;
      send_msg({5'h05, 25'h0000_001}, 64'h8000_0000_0000_0001, 2, 1'b1);
      send_msg({5'h13, 25'h1FF_FFFF}, 64'h8000_0000_0000_0001, 0, 1'b0); // R5 state chain

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule